// File: doc/BRIEF.md
# Synonym Page Bloom Filter

This block sits in front of a virtually tagged L1 cache and answers, for every access, one question: can the page that the access touches be reached through more than one virtual address? A lookup presents a virtual page number (VPN), and one cycle later the block returns a registered flag with a valid pulse. A clear flag means the page is private, so the access may use virtual tags. A set flag sends the access through a small synonym TLB so that it uses physical tags. Because the answer for a page depends only on the filter contents, every access to the same page gets the same kind of tag.

The filter is a Bloom filter made of two 1024-bit arrays. Each array is indexed by its own hash of the VPN, and a page is flagged only when both indexed bits are set. The hardware never learns the contents on its own. Software marks a synonym page by setting its bit in each array through a single-bit write port. A clear command wipes both arrays, one index per cycle. Bits are never dropped except by clear or reset, so a page that was inserted is always flagged. Aliasing can produce false positives, and these only cost an extra translation.

Top module: `synonym_filter`

## Requirements
- R1: The index into array 0 is the XOR of the 10-bit chunks of the VPN. The VPN is zero-extended to a multiple of 10 bits, and the chunks are taken from the least significant end.
- R2: The index into array 1 is built the same way from `vpn ^ (vpn << 5)`, truncated to the VPN width.
- R3: When no clear is in progress, the flag is 1 exactly when both indexed bits are set. One bit alone gives 0.
- R4: `res_valid` pulses one cycle after each cycle in which `lk_req` is high, and is low otherwise. `res_synonym` is low whenever `res_valid` is low.
- R5: A write with `wr_sel`=0 sets bit `wr_idx` of array 0, and `wr_sel`=1 sets it in array 1. A bit that has been set stays set until a clear or a reset, so an inserted page is flagged on every later lookup.
- R6: A lookup in the same cycle as an accepted write to one of its indexed bits sees that bit as set.
- R7: When `clr_start` arrives while no clear is running, `clr_busy` goes high on the next cycle and stays high for exactly 1024 cycles. After that, every bit in both arrays is 0.
- R8: A lookup issued while `clr_busy` is high returns flag 1.
- R9: A write is ignored when `clr_busy` or `clr_start` is high. A `clr_start` that arrives while a clear is running is ignored.
- R10: After reset, both arrays are empty, and `clr_busy` and `res_valid` are low.
- R11: With no write or clear in between, repeated lookups of the same VPN return the same flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 36 | Virtual page number to classify |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_synonym | output | 1 | 1 = treat as synonym (use physical tags) |
| wr_en | input | 1 | Set one filter bit |
| wr_sel | input | 1 | Array select for the write |
| wr_idx | input | 10 | Bit index for the write |
| clr_start | input | 1 | Start wiping both arrays |
| clr_busy | output | 1 | Wipe in progress |

## Verification
The assertions assume that reset is applied before the first request. They also assume that `lk_req`, `wr_en` and `clr_start` are plain level inputs that are sampled on each edge, so a request held for several cycles counts as several lookups. The bench changes every input only on the falling clock edge, drives each request as a one-cycle pulse, and lets a full wipe finish before it judges the array contents. It computes both hash indexes on its own and keeps a shadow copy of the two arrays, so it can predict both aliasing and intentional partial matches.

// File: rtl/syn_filt_pkg.sv
package syn_filt_pkg;

    localparam int VPN_W_DEF = 36;
    localparam int IDX_W_DEF = 10;
    localparam int SKEW_DEF  = 5;
    localparam int N_BANKS   = 2;

    typedef enum logic [0:0] {
        WIPE_IDLE  = 1'b0,
        WIPE_SWEEP = 1'b1
    } wipe_state_e;

    typedef struct packed {
        logic valid;
        logic flag;
    } lk_result_t;

endpackage

// File: rtl/syn_hash_unit.sv
module syn_hash_unit #(
    parameter int VPN_W   = syn_filt_pkg::VPN_W_DEF,
    parameter int IDX_W   = syn_filt_pkg::IDX_W_DEF,
    parameter int SKEW    = syn_filt_pkg::SKEW_DEF,
    parameter int VARIANT = 0
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    localparam int CHUNKS = (VPN_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [VPN_W-1:0] mixed;
    logic [PAD_W-1:0] padded;

    generate
        if (VARIANT == 0) begin : g_plain
            assign mixed = vpn;
        end else begin : g_skew
            assign mixed = vpn ^ (vpn << SKEW);
        end
    endgenerate

    assign padded = PAD_W'(mixed);

    always_comb begin
        idx = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            idx = idx ^ padded[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/syn_bit_array.sv
module syn_bit_array #(
    parameter int IDX_W = syn_filt_pkg::IDX_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             wipe_en,
    input  logic [IDX_W-1:0] wipe_idx
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
        end else begin
            if (wipe_en) begin
                bits[wipe_idx] <= 1'b0;
            end
            if (set_en) begin
                bits[set_idx] <= 1'b1;
            end
        end
    end

    // forward a same-cycle set so the lookup sees it
    assign rd_bit = bits[rd_idx] | (set_en && (set_idx == rd_idx));
endmodule

// File: rtl/syn_wipe_ctrl.sv
module syn_wipe_ctrl
    import syn_filt_pkg::*;
#(
    parameter int IDX_W = IDX_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] wipe_idx
);
    localparam logic [IDX_W-1:0] LAST = '1;

    wipe_state_e      state;
    logic [IDX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WIPE_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                WIPE_IDLE: begin
                    if (start) begin
                        state <= WIPE_SWEEP;
                        cnt   <= '0;
                    end
                end
                WIPE_SWEEP: begin
                    if (cnt == LAST) begin
                        state <= WIPE_IDLE;
                    end
                    cnt <= cnt + 1'b1;
                end
                default: state <= WIPE_IDLE;
            endcase
        end
    end

    assign busy     = (state == WIPE_SWEEP);
    assign wipe_idx = cnt;
endmodule

// File: rtl/synonym_filter.sv
module synonym_filter
    import syn_filt_pkg::*;
#(
    parameter int VPN_W = VPN_W_DEF,
    parameter int IDX_W = IDX_W_DEF,
    parameter int SKEW  = SKEW_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             res_valid,
    output logic             res_synonym,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             clr_start,
    output logic             clr_busy
);
    logic             wipe_busy;
    logic [IDX_W-1:0] wipe_idx;
    logic             wr_ok;
    logic [N_BANKS-1:0] hit;
    lk_result_t       res_q;

    syn_wipe_ctrl #(.IDX_W(IDX_W)) u_wipe (
        .clk      (clk),
        .rst      (rst),
        .start    (clr_start),
        .busy     (wipe_busy),
        .wipe_idx (wipe_idx)
    );

    // writes would be lost under a running or starting wipe
    assign wr_ok = wr_en && !wipe_busy && !clr_start;

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            logic [IDX_W-1:0] h_idx;

            syn_hash_unit #(
                .VPN_W   (VPN_W),
                .IDX_W   (IDX_W),
                .SKEW    (SKEW),
                .VARIANT (b)
            ) u_hash (
                .vpn (lk_vpn),
                .idx (h_idx)
            );

            syn_bit_array #(.IDX_W(IDX_W)) u_arr (
                .clk      (clk),
                .rst      (rst),
                .rd_idx   (h_idx),
                .rd_bit   (hit[b]),
                .set_en   (wr_ok && (wr_sel == b[0])),
                .set_idx  (wr_idx),
                .wipe_en  (wipe_busy),
                .wipe_idx (wipe_idx)
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= lk_req;
            res_q.flag  <= lk_req && (wipe_busy || (&hit));
        end
    end

    assign res_valid   = res_q.valid;
    assign res_synonym = res_q.flag;
    assign clr_busy    = wipe_busy;
endmodule

// File: rtl/synonym_filter_chk.sv
module synonym_filter_chk #(
    parameter int IDX_W = 10
) (
    input logic clk,
    input logic rst,
    input logic lk_req,
    input logic res_valid,
    input logic res_synonym,
    input logic clr_start,
    input logic clr_busy
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst || !clr_busy) busy_run <= '0;
        else                  busy_run <= busy_run + 1'b1;
    end

    // R4
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> res_valid);

    // R4
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !res_valid);

    // R4
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_synonym);

    // R8
    busy_forces_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_req && clr_busy) |=> res_synonym);

    // R7
    wipe_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_start && !clr_busy) |=> clr_busy);

    // R7
    wipe_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        clr_busy |-> (busy_run < (IDX_W+1)'(DEPTH)));

    // R7
    wipe_full_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clr_busy) |-> (busy_run == (IDX_W+1)'(DEPTH)));
endmodule

bind synonym_filter synonym_filter_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_req      (lk_req),
    .res_valid   (res_valid),
    .res_synonym (res_synonym),
    .clr_start   (clr_start),
    .clr_busy    (clr_busy)
);

// File: tb/tb_synonym_filter.sv
`timescale 1ns/1ps
module tb_synonym_filter;
    localparam int VW = 36;
    localparam int IW = 10;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst;
    logic          lk_req;
    logic [VW-1:0] lk_vpn;
    logic          res_valid, res_synonym;
    logic          wr_en, wr_sel;
    logic [IW-1:0] wr_idx;
    logic          clr_start;
    logic          clr_busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit shA [DEPTH];
    bit shB [DEPTH];

    always #5 clk = ~clk;

    synonym_filter dut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .res_valid(res_valid), .res_synonym(res_synonym),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .clr_start(clr_start), .clr_busy(clr_busy)
    );

    function automatic logic [IW-1:0] fold(input logic [VW-1:0] v);
        logic [39:0] p;
        p = {4'b0, v};
        return p[9:0] ^ p[19:10] ^ p[29:20] ^ p[39:30];
    endfunction
    function automatic logic [IW-1:0] hA(input logic [VW-1:0] v);
        return fold(v);
    endfunction
    function automatic logic [IW-1:0] hB(input logic [VW-1:0] v);
        logic [VW-1:0] m;
        m = v ^ (v << 5);
        return fold(m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_bit(input bit sel, input logic [IW-1:0] idx);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_idx = idx;
        if (!clr_busy) begin
            if (sel) shB[idx] = 1; else shA[idx] = 1;
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic insert(input logic [VW-1:0] v);
        wr_bit(0, hA(v));
        wr_bit(1, hB(v));
    endtask

    task automatic lookup(input logic [VW-1:0] v, input bit exp, input string req);
        @(negedge clk);
        lk_req = 1; lk_vpn = v;
        @(negedge clk);
        lk_req = 0;
        check({req, " valid"}, res_valid, 1);
        check({req, " flag"}, res_synonym, exp);
    endtask

    task automatic wait_wipe_done();
        for (int i = 0; i < 2000 && clr_busy; i++) @(negedge clk);
    endtask

    // R10
    task automatic t_reset();
        check("R10 busy", clr_busy, 0);
        check("R10 valid", res_valid, 0);
        lookup(36'h0_0000_1000, 0, "R10 empty");
    endtask

    // R1 R2 R3 R5 R11
    task automatic t_insert();
        logic [VW-1:0] v = 36'h1_2345_6789;
        wr_bit(0, hA(v));
        lookup(v, 0, "R3 one bit");
        wr_bit(1, hB(v));
        lookup(v, 1, "R5 inserted");
        lookup(v, 1, "R11 repeat");
        // only array 1 bit of a fresh page
        wr_bit(1, hB(36'h0_0ABC_0001));
        lookup(36'h0_0ABC_0001, shA[hA(36'h0_0ABC_0001)], "R3 b only");
    endtask

    // R4
    task automatic t_valid();
        @(negedge clk);
        check("R4 idle valid", res_valid, 0);
        check("R4 idle flag", res_synonym, 0);
        lookup(36'h1_2345_6789, 1, "R4 pulse");
        @(negedge clk);
        check("R4 drop", res_valid, 0);
    endtask

    // R6
    task automatic t_bypass();
        logic [VW-1:0] v = 36'h7_0F0F_3C3C;
        wr_bit(0, hA(v));
        @(negedge clk);
        wr_en = 1; wr_sel = 1; wr_idx = hB(v); shB[hB(v)] = 1;
        lk_req = 1; lk_vpn = v;
        @(negedge clk);
        wr_en = 0; lk_req = 0;
        check("R6 same cycle", res_synonym, 1);
    endtask

    // R1 R2 R5: many pages against the shadow model
    task automatic t_many();
        logic [VW-1:0] v;
        for (int i = 0; i < 12; i++) begin
            v = VW'(64'h9E37_79B9 * (i + 3)) ^ VW'(i << 28);
            insert(v);
        end
        for (int i = 0; i < 12; i++) begin
            v = VW'(64'h9E37_79B9 * (i + 3)) ^ VW'(i << 28);
            lookup(v, 1, "R5 no miss");
        end
        for (int i = 0; i < 16; i++) begin
            v = VW'(64'h5bd1_e995 * (i + 101));
            lookup(v, shA[hA(v)] & shB[hB(v)], "R1 R2 model");
        end
    endtask

    // R7 R8 R9
    task automatic t_wipe();
        logic [VW-1:0] v = 36'h3_3333_0042;
        int len;
        @(negedge clk);
        clr_start = 1;
        wr_en = 1; wr_sel = 0; wr_idx = hA(v);
        @(negedge clk);
        clr_start = 0; wr_en = 0;
        check("R7 busy rise", clr_busy, 1);
        lookup(36'h0_0000_0007, 1, "R8 during wipe");
        wr_bit(0, hA(v));
        @(negedge clk);
        clr_start = 1;
        @(negedge clk);
        clr_start = 0;
        len = 6;
        while (clr_busy && len < 3000) begin
            @(negedge clk);
            len++;
        end
        check("R7 length", len, DEPTH);
        check("R9 restart ignored", len, DEPTH);
        foreach (shA[i]) begin shA[i] = 0; shB[i] = 0; end
        lookup(36'h1_2345_6789, 0, "R7 emptied");
        wr_bit(1, hB(v));
        lookup(v, 0, "R9 write ignored");
    endtask

    initial begin
        rst = 1; lk_req = 0; lk_vpn = '0; wr_en = 0; wr_sel = 0;
        wr_idx = '0; clr_start = 0;
        foreach (shA[i]) begin shA[i] = 0; shB[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_insert();
        t_valid();
        t_bypass();
        t_many();
        t_wipe();
        wait_wipe_done();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule